// File: doc/BRIEF.md
# Four-Wide Rename and Allocate Stage

This block sits between instruction delivery and scheduling. Each cycle it can take one group of up to four micro-ops. Two hardware threads each offer a group on a channel of their own, and one group is chosen per cycle. Every valid slot in the chosen group receives the next reorder buffer index in program order. A fused pair sits in one slot, so it uses one index. Each slot that writes a destination register gets a fresh physical register from one of two pools, chosen by the slot's class: integer, or floating-point/SIMD. Each thread has its own alias table for each class. The alias table supplies the physical tags of the sources and records the new producer of the destination. Within a group, a later slot sees the tags that earlier slots have just been given.

A group is accepted whole or not at all. It waits while the reorder buffer or either pool lacks room for every slot in it, and while the output register is occupied and not being drained. The input channels use valid/ready. The chosen thread's ready is high only when the whole group can advance. The other thread's ready is low in that cycle. A group is taken on a cycle where valid and ready are both high, and a stalled thread keeps its payload unchanged. The output is a registered valid/ready stage that holds while ready is low. A retire port frees the oldest reorder buffer entry and hands the displaced physical register back to its pool.

Top module: `rn_alloc_stage`

## Requirements
- R1: Each thread channel carries four 16-bit slots, with slot i at bits [16i+15:16i] of that thread's 64-bit half (thread 1 in the upper half). Slot fields: bit 15 valid, bit 14 fused, bit 13 class (1 = FP/SIMD), bit 12 writes-destination, bits 11:8 destination, bits 7:4 source A, bits 3:0 source B. Ready is high only for the selected thread, and only when the group can advance and the output stage has space.
- R2: When both threads are valid, the selected thread is the one not granted at the last acceptance, starting with thread 0 after reset. When only one thread is valid, that thread is selected. The selected thread is reported on out_tid.
- R3: Valid slots receive consecutive reorder buffer indices in slot order, modulo 168. A fused slot uses exactly one index.
- R4: A group stalls if the current occupancy plus its valid slot count exceeds 168. A retire in the same cycle does not make room for it.
- R5: A group stalls if the integer pool holds fewer free registers than the group has integer destinations.
- R6: A group stalls if the FP/SIMD pool holds fewer free registers than the group has FP/SIMD destinations.
- R7: Source tags come from the thread's alias table for the slot's class. After reset, architectural register r of thread t maps to physical register 16t+r.
- R8: A source, or the displaced destination mapping, that names a register written by an earlier slot of the same class in the same group takes the newest such earlier tag.
- R9: New destination tags leave each pool in first-in first-out order. After reset, each pool holds physical registers 32 to 63 in ascending order.
- R10: A retire frees the oldest entry and appends ret_preg to the tail of its class's pool when ret_has_dst is set. A retire while the buffer is empty is ignored.
- R11: A captured output holds its valid bit and payload until out_ready is high. The fused, class and destination flags pass through unchanged.
- R12: After reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 2 | Group offered, one bit per thread |
| in_ready | output | 2 | Group accepted, one bit per thread |
| in_uops | input | 128 | Four packed slots per thread |
| out_valid | output | 1 | Renamed group present |
| out_ready | input | 1 | Consumer takes the group |
| out_tid | output | 1 | Thread of the renamed group |
| out_slot_valid | output | 4 | Per-slot valid |
| out_fused | output | 4 | Per-slot fused flag |
| out_fp | output | 4 | Per-slot class flag |
| out_has_dst | output | 4 | Per-slot destination flag |
| out_rob_idx | output | 32 | Per-slot reorder buffer index, 8 bits each |
| out_psrc_a | output | 24 | Per-slot physical source A, 6 bits each |
| out_psrc_b | output | 24 | Per-slot physical source B, 6 bits each |
| out_pdst | output | 24 | Per-slot new physical destination |
| out_pdst_old | output | 24 | Per-slot displaced physical destination |
| ret_valid | input | 1 | Retire the oldest entry |
| ret_fp | input | 1 | Class of the returned register |
| ret_has_dst | input | 1 | A register is returned |
| ret_preg | input | 6 | Register returned to its pool |

## Verification
Allocation and retirement can happen in the same cycle. In that cycle, one pool may be popped by the new group and pushed by the retiring entry, while the reorder buffer count moves in both directions. The bench drives this by running the pools near empty while retiring at random. It checks that a register returned in a cycle cannot be handed out in that same cycle, and that it is handed out later in first-in first-out order. A reference model with behavioural queues is compared against the ready lines and every output field on every clock.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned THREADS   = 2;
  localparam int unsigned ARCH_REGS = 16;
  localparam int unsigned ARCH_W    = 4;
  localparam int unsigned UOP_W     = 16;

  // Bit order is the external slot layout: valid at the top.
  typedef struct packed {
    logic              valid;
    logic              fused;
    logic              fp;
    logic              has_dst;
    logic [ARCH_W-1:0] dst;
    logic [ARCH_W-1:0] src_a;
    logic [ARCH_W-1:0] src_b;
  } uop_t;
endpackage

// File: rtl/rn_thread_arb.sv
module rn_thread_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       accept,
  output logic       sel
);
  logic last_q;

  // Contention goes to the thread not served last; otherwise the lone requester.
  assign sel = (&req) ? ~last_q : req[1];

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= 1'b1;
    else if (accept) last_q <= sel;
  end

  AST_ARB_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (&req)) |=> ((&req) -> (sel != $past(sel))))
    else $error("arbiter did not alternate"); // R2
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned PREGS      = 64,
  parameter int unsigned FIRST_FREE = 32,
  parameter int unsigned WIDTH      = 4,
  parameter int unsigned ID_W       = 6,
  parameter int unsigned AVAIL_W    = 7,
  parameter int unsigned POP_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [POP_W-1:0]        pop_cnt,
  input  logic                    push_valid,
  input  logic [ID_W-1:0]         push_id,
  output logic [AVAIL_W-1:0]      avail,
  output logic [WIDTH*ID_W-1:0]   pop_ids
);
  localparam int unsigned IDX_W    = (PREGS > 1) ? $clog2(PREGS) : 1;
  localparam int unsigned INIT_CNT = PREGS - FIRST_FREE;

  logic [ID_W-1:0]    ring [PREGS];
  logic [IDX_W-1:0]   head_q, tail_q;
  logic [AVAIL_W-1:0] count_q;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] idx, input int unsigned inc);
    int unsigned s;
    s = 32'(idx) + inc;
    if (s >= PREGS) s = s - PREGS;
    return s[IDX_W-1:0];
  endfunction

  assign avail = count_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_peek
    assign pop_ids[i*ID_W +: ID_W] = ring[step(head_q, i)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < int'(PREGS); e++)
        ring[e] <= (e < int'(INIT_CNT)) ? ID_W'(int'(FIRST_FREE) + e) : '0;
      head_q  <= '0;
      tail_q  <= IDX_W'(INIT_CNT % PREGS);
      count_q <= AVAIL_W'(INIT_CNT);
    end else begin
      head_q <= step(head_q, 32'(pop_cnt));
      if (push_valid) begin
        ring[tail_q] <= push_id;
        tail_q       <= step(tail_q, 1);
      end
      count_q <= count_q - AVAIL_W'(pop_cnt) + AVAIL_W'(push_valid);
    end
  end

  AST_FL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pop_cnt) <= 32'(count_q))
    else $error("pool popped beyond its contents"); // R5
  AST_FL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (32'(count_q) + 1 - 32'(pop_cnt)) <= PREGS)
    else $error("pool pushed beyond capacity"); // R10
endmodule

// File: rtl/rn_rob_alloc.sv
module rn_rob_alloc #(
  parameter int unsigned DEPTH = 168,
  parameter int unsigned WIDTH = 4,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] slot_req,
  input  logic             alloc,
  input  logic             release_req,
  output logic             room,
  output logic             release_ok,
  output logic [IDX_W-1:0] idx [WIDTH]
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] tail_q;
  logic [CNT_W-1:0] count_q;
  int unsigned      need;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p, input int unsigned inc);
    int unsigned s;
    s = 32'(p) + inc;
    if (s >= DEPTH) s = s - DEPTH;
    return s[IDX_W-1:0];
  endfunction

  always_comb begin
    int unsigned ofs;
    ofs  = 0;
    need = 32'($countones(slot_req));
    for (int i = 0; i < int'(WIDTH); i++) begin
      idx[i] = step(tail_q, ofs);
      if (slot_req[i]) ofs = ofs + 1;
    end
  end

  assign room       = (32'(count_q) + need) <= DEPTH;
  assign release_ok = release_req && (count_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (alloc) tail_q <= step(tail_q, need);
      count_q <= count_q + (alloc ? CNT_W'(need) : '0) - CNT_W'(release_ok);
    end
  end

  AST_ROB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count_q) <= DEPTH)
    else $error("reorder buffer overfilled"); // R4
  AST_ROB_IDLE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (release_req && (count_q == '0) && !alloc) |=> (count_q == '0))
    else $error("retire on empty buffer changed occupancy"); // R10
endmodule

// File: rtl/rn_alias_table.sv
module rn_alias_table
  import rn_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned PREG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tid,
  input  uop_t              uops     [WIDTH],
  input  logic [PREG_W-1:0] new_pdst [WIDTH],
  input  logic              commit,
  output logic [PREG_W-1:0] psrc_a   [WIDTH],
  output logic [PREG_W-1:0] psrc_b   [WIDTH],
  output logic [PREG_W-1:0] pdst_old [WIDTH]
);
  logic [PREG_W-1:0] map_q [THREADS][2][ARCH_REGS];

  // Lookups, overridden by the newest earlier writer of the same class in the group.
  always_comb begin
    for (int i = 0; i < int'(WIDTH); i++) begin
      psrc_a[i]   = map_q[tid][uops[i].fp][uops[i].src_a];
      psrc_b[i]   = map_q[tid][uops[i].fp][uops[i].src_b];
      pdst_old[i] = map_q[tid][uops[i].fp][uops[i].dst];
      for (int j = 0; j < i; j++) begin
        if (uops[j].valid && uops[j].has_dst && (uops[j].fp == uops[i].fp)) begin
          if (uops[j].dst == uops[i].src_a) psrc_a[i]   = new_pdst[j];
          if (uops[j].dst == uops[i].src_b) psrc_b[i]   = new_pdst[j];
          if (uops[j].dst == uops[i].dst)   pdst_old[i] = new_pdst[j];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < int'(THREADS); t++)
        for (int c = 0; c < 2; c++)
          for (int r = 0; r < int'(ARCH_REGS); r++)
            map_q[t][c][r] <= PREG_W'(t * int'(ARCH_REGS) + r);
    end else if (commit) begin
      for (int i = 0; i < int'(WIDTH); i++)
        if (uops[i].valid && uops[i].has_dst)
          map_q[tid][uops[i].fp][uops[i].dst] <= new_pdst[i];
    end
  end
endmodule

// File: rtl/rn_alloc_stage.sv
module rn_alloc_stage
  import rn_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned ROB_DEPTH = 168,
  parameter int unsigned INT_PREGS = 64,
  parameter int unsigned FP_PREGS  = 64,
  parameter int unsigned ROB_W     = $clog2(ROB_DEPTH),
  parameter int unsigned PREG_W    = $clog2((INT_PREGS > FP_PREGS) ? INT_PREGS : FP_PREGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [THREADS-1:0]        in_valid,
  output logic [THREADS-1:0]        in_ready,
  input  logic [THREADS*WIDTH*UOP_W-1:0] in_uops,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic                      out_tid,
  output logic [WIDTH-1:0]          out_slot_valid,
  output logic [WIDTH-1:0]          out_fused,
  output logic [WIDTH-1:0]          out_fp,
  output logic [WIDTH-1:0]          out_has_dst,
  output logic [WIDTH*ROB_W-1:0]    out_rob_idx,
  output logic [WIDTH*PREG_W-1:0]   out_psrc_a,
  output logic [WIDTH*PREG_W-1:0]   out_psrc_b,
  output logic [WIDTH*PREG_W-1:0]   out_pdst,
  output logic [WIDTH*PREG_W-1:0]   out_pdst_old,
  input  logic                      ret_valid,
  input  logic                      ret_fp,
  input  logic                      ret_has_dst,
  input  logic [PREG_W-1:0]         ret_preg
);
  localparam int unsigned GROUP_W = WIDTH * UOP_W;
  localparam int unsigned POP_W   = $clog2(WIDTH + 1);
  localparam int unsigned AVAIL_W = PREG_W + 1;

  logic               sel, fire, res_ok, out_space, rob_room, ret_ok;
  logic [GROUP_W-1:0] grp;
  uop_t               uops [WIDTH];
  logic [WIDTH-1:0]   slot_req;
  logic [POP_W-1:0]   int_rank [WIDTH];
  logic [POP_W-1:0]   fp_rank  [WIDTH];
  logic [POP_W-1:0]   pool_need [2];
  logic [AVAIL_W-1:0] pool_avail [2];
  logic [WIDTH*PREG_W-1:0] pool_ids [2];
  logic [PREG_W-1:0]  new_pdst [WIDTH];
  logic [PREG_W-1:0]  psrc_a [WIDTH], psrc_b [WIDTH], pdst_old [WIDTH];
  logic [ROB_W-1:0]   rob_idx [WIDTH];

  // Thread choice and group unpacking
  rn_thread_arb u_arb (
    .clk(clk), .rst_n(rst_n), .req(in_valid), .accept(fire), .sel(sel)
  );

  assign grp = sel ? in_uops[GROUP_W +: GROUP_W] : in_uops[0 +: GROUP_W];

  for (genvar i = 0; i < WIDTH; i++) begin : g_unpack
    assign uops[i]     = uop_t'(grp[i*UOP_W +: UOP_W]);
    assign slot_req[i] = uops[i].valid;
  end

  // Per-class rank of each destination inside the group
  always_comb begin
    logic [POP_W-1:0] ni, nf;
    ni = '0;
    nf = '0;
    for (int i = 0; i < int'(WIDTH); i++) begin
      int_rank[i] = ni;
      fp_rank[i]  = nf;
      if (uops[i].valid && uops[i].has_dst) begin
        if (uops[i].fp) nf = nf + 1'b1;
        else            ni = ni + 1'b1;
      end
    end
    pool_need[0] = ni;
    pool_need[1] = nf;
  end

  // One free pool per register class
  for (genvar c = 0; c < 2; c++) begin : g_pool
    localparam int unsigned NREGS = (c == 0) ? INT_PREGS : FP_PREGS;
    logic push_c;
    assign push_c = ret_ok && ret_has_dst && (ret_fp == c[0]);
    rn_free_list #(
      .PREGS(NREGS), .FIRST_FREE(THREADS * ARCH_REGS), .WIDTH(WIDTH),
      .ID_W(PREG_W), .AVAIL_W(AVAIL_W), .POP_W(POP_W)
    ) u_pool (
      .clk(clk), .rst_n(rst_n),
      .pop_cnt(fire ? pool_need[c] : '0),
      .push_valid(push_c), .push_id(ret_preg),
      .avail(pool_avail[c]), .pop_ids(pool_ids[c])
    );
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pick
    assign new_pdst[i] = !(uops[i].valid && uops[i].has_dst) ? '0 :
                         uops[i].fp ? pool_ids[1][fp_rank[i]*PREG_W +: PREG_W]
                                    : pool_ids[0][int_rank[i]*PREG_W +: PREG_W];
  end

  rn_rob_alloc #(.DEPTH(ROB_DEPTH), .WIDTH(WIDTH), .IDX_W(ROB_W)) u_rob (
    .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .alloc(fire),
    .release_req(ret_valid), .room(rob_room), .release_ok(ret_ok), .idx(rob_idx)
  );

  rn_alias_table #(.WIDTH(WIDTH), .PREG_W(PREG_W)) u_rat (
    .clk(clk), .rst_n(rst_n), .tid(sel), .uops(uops), .new_pdst(new_pdst),
    .commit(fire), .psrc_a(psrc_a), .psrc_b(psrc_b), .pdst_old(pdst_old)
  );

  // All-or-nothing admission
  assign res_ok    = rob_room
                  && (AVAIL_W'(pool_need[0]) <= pool_avail[0])
                  && (AVAIL_W'(pool_need[1]) <= pool_avail[1]);
  assign out_space = !out_valid || out_ready;
  assign in_ready  = (out_space && res_ok) ? (sel ? 2'b10 : 2'b01) : 2'b00;
  assign fire      = in_valid[sel] && out_space && res_ok;

  // Registered output stage
  logic [WIDTH-1:0]  sv_q, fu_q, fp_q, hd_q;
  logic [ROB_W-1:0]  rob_q [WIDTH];
  logic [PREG_W-1:0] pa_q [WIDTH], pb_q [WIDTH], pd_q [WIDTH], po_q [WIDTH];
  logic              tid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      tid_q     <= 1'b0;
      sv_q <= '0; fu_q <= '0; fp_q <= '0; hd_q <= '0;
      for (int i = 0; i < int'(WIDTH); i++) begin
        rob_q[i] <= '0; pa_q[i] <= '0; pb_q[i] <= '0; pd_q[i] <= '0; po_q[i] <= '0;
      end
    end else if (fire) begin
      out_valid <= 1'b1;
      tid_q     <= sel;
      for (int i = 0; i < int'(WIDTH); i++) begin
        sv_q[i]  <= uops[i].valid;
        fu_q[i]  <= uops[i].fused;
        fp_q[i]  <= uops[i].fp;
        hd_q[i]  <= uops[i].has_dst;
        rob_q[i] <= rob_idx[i];
        pa_q[i]  <= psrc_a[i];
        pb_q[i]  <= psrc_b[i];
        pd_q[i]  <= new_pdst[i];
        po_q[i]  <= pdst_old[i];
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_tid        = tid_q;
  assign out_slot_valid = sv_q;
  assign out_fused      = fu_q;
  assign out_fp         = fp_q;
  assign out_has_dst    = hd_q;
  for (genvar i = 0; i < WIDTH; i++) begin : g_flat
    assign out_rob_idx[i*ROB_W +: ROB_W]   = rob_q[i];
    assign out_psrc_a[i*PREG_W +: PREG_W]  = pa_q[i];
    assign out_psrc_b[i*PREG_W +: PREG_W]  = pb_q[i];
    assign out_pdst[i*PREG_W +: PREG_W]    = pd_q[i];
    assign out_pdst_old[i*PREG_W +: PREG_W] = po_q[i];
  end

  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready))
    else $error("both threads ready"); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rob_idx) && $stable(out_pdst)
                                   && $stable(out_slot_valid)))
    else $error("output changed while stalled"); // R11
endmodule

// File: tb/rn_alloc_stage_tb_top.sv
module rn_alloc_stage_tb_top;
  localparam int W = 4, DEPTH = 168, UW = 16, RW = 8, PW = 6, AR = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     in_valid = '0;
  logic [1:0]     in_ready;
  logic [2*W*UW-1:0] in_uops = '0;
  logic           out_valid, out_ready = 1'b0, out_tid;
  logic [W-1:0]   out_slot_valid, out_fused, out_fp, out_has_dst;
  logic [W*RW-1:0] out_rob_idx;
  logic [W*PW-1:0] out_psrc_a, out_psrc_b, out_pdst, out_pdst_old;
  logic           ret_valid = 1'b0, ret_fp = 1'b0, ret_has_dst = 1'b0;
  logic [PW-1:0]  ret_preg = '0;

  always #5 clk = ~clk;

  rn_alloc_stage dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_uops(in_uops),
    .out_valid(out_valid), .out_ready(out_ready), .out_tid(out_tid),
    .out_slot_valid(out_slot_valid), .out_fused(out_fused), .out_fp(out_fp),
    .out_has_dst(out_has_dst), .out_rob_idx(out_rob_idx), .out_psrc_a(out_psrc_a),
    .out_psrc_b(out_psrc_b), .out_pdst(out_pdst), .out_pdst_old(out_pdst_old),
    .ret_valid(ret_valid), .ret_fp(ret_fp), .ret_has_dst(ret_has_dst), .ret_preg(ret_preg)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  int rat [2][2][AR];
  int fq_int[$], fq_fp[$];
  int rq_hd[$], rq_fp[$], rq_pr[$];
  int rob_cnt, rob_tail, last_sel;
  bit e_valid;
  int e_tid;
  int e_sv[W], e_fu[W], e_fp[W], e_hd[W], e_rob[W], e_pa[W], e_pb[W], e_pd[W], e_po[W];
  int m_sel, m_n, m_ni, m_nf;
  bit m_space, m_rob_ok, m_int_ok, m_fp_ok;
  bit e_rdy[2];
  int cov_rob = 0, cov_int = 0, cov_fp = 0, cov_byp = 0, cov_idle_ret = 0, cov_alt = 0, cov_hold = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [UW-1:0] slot_of(input int t, input int i);
    return in_uops[(t*W + i)*UW +: UW];
  endfunction

  task automatic model_reset();
    for (int t = 0; t < 2; t++)
      for (int c = 0; c < 2; c++)
        for (int r = 0; r < AR; r++) rat[t][c][r] = t*AR + r;
    fq_int.delete(); fq_fp.delete();
    for (int p = 32; p < 64; p++) begin fq_int.push_back(p); fq_fp.push_back(p); end
    rq_hd.delete(); rq_fp.delete(); rq_pr.delete();
    rob_cnt = 0; rob_tail = 0; last_sel = 1; e_valid = 0;
  endtask

  task automatic model_eval();
    logic [UW-1:0] u;
    m_sel = (in_valid == 2'b11) ? 1 - last_sel : (in_valid[1] ? 1 : 0);
    m_n = 0; m_ni = 0; m_nf = 0;
    for (int i = 0; i < W; i++) begin
      u = slot_of(m_sel, i);
      if (u[15]) begin
        m_n++;
        if (u[12]) begin if (u[13]) m_nf++; else m_ni++; end
      end
    end
    m_space  = !e_valid || out_ready;
    m_rob_ok = (rob_cnt + m_n) <= DEPTH;
    m_int_ok = m_ni <= fq_int.size();
    m_fp_ok  = m_nf <= fq_fp.size();
    for (int t = 0; t < 2; t++)
      e_rdy[t] = (m_sel == t) && m_space && m_rob_ok && m_int_ok && m_fp_ok;
  endtask

  task automatic compare();
    string why;
    why = !m_rob_ok ? "R4" : !m_int_ok ? "R5" : !m_fp_ok ? "R6" : "R1";
    for (int t = 0; t < 2; t++) chk(in_ready[t] == e_rdy[t], why, int'(in_ready[t]), int'(e_rdy[t]));
    chk(out_valid == e_valid, "R11", int'(out_valid), int'(e_valid));
    if (e_valid && out_valid) begin
      chk(int'(out_tid) == e_tid, "R2", int'(out_tid), e_tid);
      for (int i = 0; i < W; i++) begin
        chk(int'(out_slot_valid[i]) == e_sv[i], "R1", int'(out_slot_valid[i]), e_sv[i]);
        if (e_sv[i] != 0) begin
          chk(int'(out_fused[i]) == e_fu[i], "R11", int'(out_fused[i]), e_fu[i]);
          chk(int'(out_fp[i]) == e_fp[i], "R11", int'(out_fp[i]), e_fp[i]);
          chk(int'(out_has_dst[i]) == e_hd[i], "R11", int'(out_has_dst[i]), e_hd[i]);
          chk(int'(out_rob_idx[i*RW +: RW]) == e_rob[i], "R3", int'(out_rob_idx[i*RW +: RW]), e_rob[i]);
          chk(int'(out_psrc_a[i*PW +: PW]) == e_pa[i], "R7", int'(out_psrc_a[i*PW +: PW]), e_pa[i]);
          chk(int'(out_psrc_b[i*PW +: PW]) == e_pb[i], "R7", int'(out_psrc_b[i*PW +: PW]), e_pb[i]);
          if (e_hd[i] != 0) begin
            chk(int'(out_pdst[i*PW +: PW]) == e_pd[i], "R9", int'(out_pdst[i*PW +: PW]), e_pd[i]);
            chk(int'(out_pdst_old[i*PW +: PW]) == e_po[i], "R8", int'(out_pdst_old[i*PW +: PW]), e_po[i]);
          end
        end
      end
    end
  endtask

  task automatic model_commit();
    bit fire, ret_ok;
    logic [UW-1:0] u;
    bit wr [2][AR];
    int c, np;
    fire   = in_valid[m_sel] && e_rdy[m_sel];
    ret_ok = ret_valid && (rob_cnt > 0);
    if (in_valid[m_sel]) begin
      if (!m_rob_ok) cov_rob++;
      if (!m_int_ok) cov_int++;
      if (!m_fp_ok)  cov_fp++;
    end
    if (ret_valid && rob_cnt == 0) cov_idle_ret++;
    if (e_valid && !out_ready) cov_hold++;
    if (fire) begin
      if (in_valid == 2'b11) cov_alt++;
      for (int cc = 0; cc < 2; cc++) for (int r = 0; r < AR; r++) wr[cc][r] = 0;
      e_valid = 1; e_tid = m_sel;
      for (int i = 0; i < W; i++) begin
        u = slot_of(m_sel, i);
        e_sv[i] = u[15]; e_fu[i] = u[14]; e_fp[i] = u[13]; e_hd[i] = u[12];
        if (u[15]) begin
          c = u[13];
          e_rob[i] = rob_tail; rob_tail = (rob_tail + 1) % DEPTH;
          if (wr[c][u[7:4]] || wr[c][u[3:0]]) cov_byp++;
          e_pa[i] = rat[m_sel][c][u[7:4]];
          e_pb[i] = rat[m_sel][c][u[3:0]];
          if (u[12]) begin
            e_po[i] = rat[m_sel][c][u[11:8]];
            np = (c != 0) ? fq_fp.pop_front() : fq_int.pop_front();
            e_pd[i] = np;
            rat[m_sel][c][u[11:8]] = np;
            wr[c][u[11:8]] = 1;
          end
          rq_hd.push_back(u[12]); rq_fp.push_back(c); rq_pr.push_back(u[12] ? e_po[i] : 0);
        end
      end
      last_sel = m_sel;
      rob_cnt += m_n;
    end else if (out_ready) begin
      e_valid = 0;
    end
    if (ret_ok) begin
      if (ret_has_dst) begin
        if (ret_fp) fq_fp.push_back(int'(ret_preg)); else fq_int.push_back(int'(ret_preg));
      end
      void'(rq_hd.pop_front()); void'(rq_fp.pop_front()); void'(rq_pr.pop_front());
      rob_cnt--;
    end
  endtask

  // Stimulus: reg_mask narrows register numbers to force collisions
  task automatic drive(input int pv, input int phd, input int pret, input int prdy, input int reg_mask);
    logic [UW-1:0] u;
    for (int t = 0; t < 2; t++) begin
      in_valid[t] = ($urandom % 100) < pv;
      for (int i = 0; i < W; i++) begin
        u = '0;
        u[15] = ($urandom % 8) != 0;
        u[14] = $urandom % 2;
        u[13] = $urandom % 2;
        u[12] = ($urandom % 100) < phd;
        u[11:8] = 4'($urandom) & 4'(reg_mask);
        u[7:4]  = 4'($urandom) & 4'(reg_mask);
        u[3:0]  = 4'($urandom) & 4'(reg_mask);
        in_uops[(t*W + i)*UW +: UW] = u;
      end
    end
    out_ready = ($urandom % 100) < prdy;
    ret_valid = 0; ret_has_dst = 0; ret_fp = 0; ret_preg = '0;
    if (($urandom % 100) < pret) begin
      ret_valid = 1;
      if (rq_hd.size() > 0) begin
        ret_has_dst = rq_hd[0][0]; ret_fp = rq_fp[0][0]; ret_preg = PW'(rq_pr[0]);
      end else begin
        ret_has_dst = 1; ret_fp = 0; ret_preg = 6'd5;  // must be ignored (R10)
      end
    end
  endtask

  task automatic run_phase(input int cycles, input int pv, input int phd, input int pret,
                           input int prdy, input int reg_mask);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      drive(pv, phd, pret, prdy, reg_mask);
      #1;
      model_eval();
      compare();
      model_commit();
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R12", int'(out_valid), 0);
    run_phase(2000, 80, 75, 30, 70, 3);    // pools run dry, heavy in-group reuse
    run_phase(1500, 90, 0, 0, 90, 15);     // no destinations, no retire: buffer fills
    run_phase(2000, 10, 50, 90, 90, 15);   // drain, then idle retires
    run_phase(1500, 70, 60, 50, 60, 15);   // mixed
    @(negedge clk);
    in_valid = '0; ret_valid = 0;
    chk(cov_rob > 0, "R4", cov_rob, 1);
    chk(cov_int > 0, "R5", cov_int, 1);
    chk(cov_fp > 0, "R6", cov_fp, 1);
    chk(cov_byp > 0, "R8", cov_byp, 1);
    chk(cov_idle_ret > 0, "R10", cov_idle_ret, 1);
    chk(cov_alt > 0, "R2", cov_alt, 1);
    chk(cov_hold > 0, "R11", cov_hold, 1);
    done = 1;
    finish_run();
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end
endmodule